// File: doc/BRIEF.md
# Caller-ID FSK Word Receiver

This block takes a caller-ID bit stream that has already been demodulated to logic levels (mark is 1, space is 0). It frames the stream into 8-bit words with asynchronous start and stop bits. The line is sampled on a strobe `os_tick` that pulses at sixteen times the bit rate. A start bit is confirmed when the line is still space at mid-bit. Each later bit is taken at its centre.

A caller-ID burst begins with an alternating 1010 preamble. A long run of marks follows, and then the message words. The receiver watches for that run of marks and raises a sticky begin-of-mark flag. When `bom_mask` is high, word interrupts are held back until that flag is up, so the preamble is silent. When `bom_mask` is low, the preamble is framed and reported like any other data. Each accepted word is latched into `rx_data`, sets `fsk_irq_flag` and pulls `irq_n` low until the host acknowledges the read with `irq_ack`.

Top module: `cid_fsk_rx`

## Requirements
- R1: After reset, `rx_data` is 0x00, `bom_flag` and `fsk_irq_flag` are 0, and `irq_n` is 1.
- R2: A word is a space start bit, eight data bits sent least significant bit first, and a mark stop bit, each 16 samples long. When a word is accepted, its value is loaded into `rx_data`, `fsk_irq_flag` goes to 1 and `irq_n` goes to 0.
- R3: A pulse on `irq_ack` clears `fsk_irq_flag` and returns `irq_n` to 1. If a new word is accepted in the same cycle, the flag stays set.
- R4: A word whose stop bit samples as space is dropped. `rx_data` keeps its old value and no interrupt is raised.
- R5: `bom_flag` goes to 1 once 640 consecutive mark samples have been taken (40 bit times). It is still 0 after 39 bit times of marks.
- R6: Once set, `bom_flag` stays set for as long as `rx_en` stays high.
- R7: While `bom_mask` is 1 and `bom_flag` is 0, framed words raise no interrupt and do not load `rx_data`. An alternating preamble therefore produces no interrupt.
- R8: While `bom_mask` is 0, the alternating preamble is framed as data words and raises interrupts.
- R9: A line held at mark never raises an interrupt.
- R10: While `rx_en` is 0, no framing takes place, `bom_flag` and `fsk_irq_flag` are held at 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Line sample strobe at 16x the bit rate |
| rx_line | input | 1 | Demodulated line bit, 1 = mark |
| rx_en | input | 1 | Receiver enable |
| bom_mask | input | 1 | 1 = hold word interrupts until begin-of-mark |
| irq_ack | input | 1 | Data register read, clears the interrupt |
| rx_data | output | 8 | Last accepted word |
| bom_flag | output | 1 | Begin-of-mark seen |
| fsk_irq_flag | output | 1 | Word interrupt pending |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is the begin-of-mark threshold itself. The preamble is full of marks, so the mark count must be reset by a space at a known point and then stopped exactly one bit time short of the limit. The bench gets there by disabling and re-enabling the receiver, sending a preamble that ends on a space, and then sending 39 mark bits. It checks that the flag is still low at that point and that it rises after the 40th mark bit.

// File: rtl/cid_fsk_pkg.sv
package cid_fsk_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_e;
endpackage

// File: rtl/cid_rst_sync.sv
module cid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cid_bit_framer.sv
module cid_bit_framer #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             line,
  output logic             word_ok,
  output logic [DBITS-1:0] word
);
  import cid_fsk_pkg::*;
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DBITS + 1);
  localparam int HALF = OVS / 2;

  fr_state_e        st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [BW-1:0]    idx_q, idx_d;
  logic [DBITS-1:0] sh_q, sh_d;
  logic             ok_q, ok_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    ok_d  = 1'b0;
    if (!en) begin
      st_d  = FR_IDLE;
      cnt_d = '0;
      idx_d = '0;
    end else if (tick) begin
      case (st_q)
        FR_IDLE: begin
          cnt_d = '0;
          if (!line) st_d = FR_START;
        end
        FR_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = line ? FR_IDLE : FR_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FR_DATA: begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[DBITS-1:1]};
            idx_d = idx_q + 1'b1;
            if (idx_q == BW'(DBITS - 1)) st_d = FR_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FR_STOP: begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            ok_d  = line;
            st_d  = FR_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      ok_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      ok_q  <= ok_d;
    end
  end

  assign word_ok = ok_q;
  assign word    = sh_q;
endmodule

// File: rtl/cid_mark_run.sv
module cid_mark_run #(
  parameter int OVS      = 16,
  parameter int BOM_BITS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic line,
  output logic bom
);
  localparam int LIM = OVS * BOM_BITS;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] run_q, run_d;
  logic          bom_q, bom_d;

  always_comb begin
    run_d = run_q;
    bom_d = bom_q;
    if (!en) begin
      run_d = '0;
      bom_d = 1'b0;
    end else if (tick) begin
      if (!line) begin
        run_d = '0;
      end else if (run_q == CW'(LIM - 1)) begin
        bom_d = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      bom_q <= 1'b0;
    end else begin
      run_q <= run_d;
      bom_q <= bom_d;
    end
  end

  assign bom = bom_q;
endmodule

// File: rtl/cid_fsk_rx.sv
module cid_fsk_rx #(
  parameter int OVS      = 16,
  parameter int DBITS    = 8,
  parameter int BOM_BITS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             rx_line,
  input  logic             rx_en,
  input  logic             bom_mask,
  input  logic             irq_ack,
  output logic [DBITS-1:0] rx_data,
  output logic             bom_flag,
  output logic             fsk_irq_flag,
  output logic             irq_n
);
  logic             rst_ni;
  logic             word_ok;
  logic [DBITS-1:0] word;
  logic             accept;
  logic [DBITS-1:0] data_q, data_d;
  logic             irq_q, irq_d;

  cid_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  cid_bit_framer #(.OVS(OVS), .DBITS(DBITS)) u_framer (
    .clk(clk), .rst_n(rst_ni), .en(rx_en), .tick(os_tick), .line(rx_line),
    .word_ok(word_ok), .word(word)
  );

  cid_mark_run #(.OVS(OVS), .BOM_BITS(BOM_BITS)) u_bom (
    .clk(clk), .rst_n(rst_ni), .en(rx_en), .tick(os_tick), .line(rx_line),
    .bom(bom_flag)
  );

  assign accept = rx_en && word_ok && (!bom_mask || bom_flag);

  always_comb begin
    data_d = data_q;
    irq_d  = irq_q;
    if (!rx_en) begin
      irq_d = 1'b0;
    end else if (accept) begin
      data_d = word;
      irq_d  = 1'b1;
    end else if (irq_ack) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      irq_q  <= irq_d;
    end
  end

  assign rx_data      = data_q;
  assign fsk_irq_flag = irq_q;
  assign irq_n        = ~irq_q;
endmodule

// File: rtl/cid_fsk_rx_chk.sv
module cid_fsk_rx_chk #(
  parameter int DBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_line,
  input logic             rx_en,
  input logic             bom_mask,
  input logic [DBITS-1:0] rx_data,
  input logic             bom_flag,
  input logic             fsk_irq_flag,
  input logic             irq_n
);
  // R10: disabling clears both flags on the next cycle
  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!bom_flag && !fsk_irq_flag));

  // R7: an interrupt only rises when the gate was open
  p_gate_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsk_irq_flag) |-> $past(!bom_mask || bom_flag));

  // R5: begin-of-mark only rises after a mark sample
  p_bom_after_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bom_flag) |-> $past(rx_line));

  // R6: begin-of-mark is sticky while enabled
  p_bom_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bom_flag && rx_en) |=> bom_flag);

  // R2: the data register only changes when a word interrupt is raised
  p_data_with_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> fsk_irq_flag);

  // R10: IRQ is only asserted while the receiver was enabled
  p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(rx_en));
endmodule

bind cid_fsk_rx cid_fsk_rx_chk #(.DBITS(DBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_en(rx_en),
  .bom_mask(bom_mask), .rx_data(rx_data), .bom_flag(bom_flag),
  .fsk_irq_flag(fsk_irq_flag), .irq_n(irq_n)
);

// File: tb/cid_fsk_rx_test.sv
module cid_fsk_rx_test;
  logic       clk;
  logic       rst_n;
  logic       os_tick;
  logic       rx_line;
  logic       rx_en;
  logic       bom_mask;
  logic       irq_ack;
  logic [7:0] rx_data;
  logic       bom_flag;
  logic       fsk_irq_flag;
  logic       irq_n;

  int  n_chk;
  int  n_bad;
  bit  watch;
  bit  irq_seen;
  bit  done;

  cid_fsk_rx uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .rx_en(rx_en), .bom_mask(bom_mask), .irq_ack(irq_ack),
    .rx_data(rx_data), .bom_flag(bom_flag), .fsk_irq_flag(fsk_irq_flag),
    .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (watch && !irq_n) irq_seen = 1'b1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] v, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    send_bit(stop);
    send_bit(1'b1);
  endtask

  task automatic seizure(input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(i[0] ? 1'b0 : 1'b1);
  endtask

  task automatic marks(input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(1'b1);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [6];
    vals = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    rst_n = 1'b0; os_tick = 1'b1; rx_line = 1'b1; rx_en = 1'b0;
    bom_mask = 1'b1; irq_ack = 1'b0; watch = 1'b0; irq_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 data", rx_data, 0);
    check("R1 bom", bom_flag, 0);
    check("R1 irqflag", fsk_irq_flag, 0);
    check("R1 irq_n", irq_n, 1);

    // R10: a word sent while disabled is not framed
    send_word(8'h3C, 1'b1);
    check("R10 no frame data", rx_data, 0);
    check("R10 no frame irq", irq_n, 1);

    // R7: masked preamble gives no interrupt
    rx_en = 1'b1;
    watch = 1'b1; irq_seen = 1'b0;
    seizure(60);
    watch = 1'b0;
    check("R7 preamble silent", irq_seen, 0);
    check("R7 data untouched", rx_data, 0);
    check("R5 bom low after preamble", bom_flag, 0);
    marks(45);
    check("R5 bom set", bom_flag, 1);

    // R2/R3 word sweep
    foreach (vals[k]) begin
      send_word(vals[k], 1'b1);
      check("R2 data", rx_data, vals[k]);
      check("R2 irqflag", fsk_irq_flag, 1);
      check("R2 irq_n", irq_n, 0);
      ack();
      check("R3 ack flag", fsk_irq_flag, 0);
      check("R3 ack irq_n", irq_n, 1);
      check("R6 bom sticky", bom_flag, 1);
    end

    // R4 framing error
    send_word(8'hC3, 1'b0);
    marks(2);
    check("R4 data kept", rx_data, 8'h80);
    check("R4 no irq", irq_n, 1);

    // R10 disable clears flags
    send_word(8'h77, 1'b1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 bom cleared", bom_flag, 0);
    check("R10 irq cleared", fsk_irq_flag, 0);
    check("R10 irq_n high", irq_n, 1);

    // R8 unmasked preamble raises interrupts
    bom_mask = 1'b0;
    rx_en = 1'b1;
    watch = 1'b1; irq_seen = 1'b0;
    seizure(20);
    watch = 1'b0;
    check("R8 preamble irq", irq_seen, 1);
    marks(12);
    ack();

    // R9 marks alone never interrupt
    watch = 1'b1; irq_seen = 1'b0;
    marks(50);
    watch = 1'b0;
    check("R9 marks silent", irq_seen, 0);

    // R5 threshold boundary
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    rx_en = 1'b1;
    seizure(6);
    marks(39);
    check("R5 39 bits", bom_flag, 0);
    marks(1);
    repeat (2) @(negedge clk);
    check("R5 40 bits", bom_flag, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule